// File: doc/BRIEF.md
# Lifecycle Access Gate with Password Verification

This block sits next to the serial protocol engine of a bit-addressed memory card and decides, for the bit address on its input, which kind of access is allowed. The answer is a 2-bit code: read-only, program-once, rewritable or read-protected. The code depends on the region that holds the address and on the card's lifecycle stage. There are four stages. OPEN means the transmission password is not yet verified. VERIFIED means it has been proven. PERSONALIZED means the personalization flag has been written. USER means that, after personalization, the user password has also been proven.

The block keeps its own copies of the security bits. These are the eight-bit attempt counter, the 24-bit transmission password, the personalization flag, the eight-bit user attempt counter and the eight-bit user password. When the engine writes a 0 over a set attempt-counter bit, the block starts a comparison. It takes one presented bit per `pw_valid` strobe and matches it against the stored secret in ascending address order. The three comparison states are CS_IDLE, CS_COMPARE and CS_DECIDE. A start request moves CS_IDLE to CS_COMPARE. The last strobe moves CS_COMPARE to CS_DECIDE. CS_DECIDE always returns to CS_IDLE and grants the right if no bit differed. While the block is not in CS_IDLE it reports `busy` and ignores every request.

An attempt counter with no set bit left locks the gate, and no comparison can then succeed. Once the transmission password is proven, an erase request on the counter sets all of its bits back to 1.

Top module: `acs_access_ctrl`

## Requirements
- R1: Addresses 0 to 15 report code 00 (read-only) in every lifecycle stage.
- R2: Addresses 16 to 71, including the personalization flag at 64, report 01 (program-once) in VERIFIED and 00 in every other stage.
- R3: Addresses 72 to 79 (attempt counter, bit i at address 72+i) report 01 in OPEN and 10 (rewritable) in every other stage.
- R4: Addresses 80 to 103 (transmission password, bit i at address 80+i) report 11 (read-protected) in OPEN and 10 in every other stage.
- R5: Addresses 104 to 143 report 10 only in VERIFIED and 00 otherwise. Addresses 160 to 255 report 10 in VERIFIED and USER and 00 otherwise.
- R6: Addresses 144 to 151 (user counter) report 00, 10, 01, 10 in OPEN, VERIFIED, PERSONALIZED, USER. Addresses 152 to 159 (user password) report 00, 10, 11, 10 in the same stages.
- R7: In OPEN, a write request (op_kind 01) with op_data 0 to a set attempt-counter bit, while at least two counter bits are set, clears that bit and raises busy at the accepting edge. The next 24 strobed bits are compared, first bit against address 80. If all 24 match, verified rises and busy falls at the edge after the one that takes the last bit.
- R8: If any presented bit differs, verified stays 0 and the cleared counter bit stays cleared.
- R9: A write that clears the last set counter bit starts no comparison and asserts locked. While locked, verified cannot rise.
- R10: In VERIFIED, an erase request (op_kind 10) to any address 72 to 79 sets all eight counter bits to 1.
- R11: Requests are ignored while busy, and so is any write of 1 or any write to a read-only code. Only an erase sets stored bits.
- R12: In VERIFIED, a write of 0 to address 64 sets personalized and clears verified at the same edge. From then on, locked reflects the user counter.
- R13: In PERSONALIZED, a write of 0 to a set user-counter bit, while at least two of its bits are set, starts an 8-bit comparison against addresses 152 to 159. A full match raises user_ok at the same point as in R7.
- R14: After reset, verified, user_ok, personalized, locked and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Current bit address |
| op_req | input | 1 | Request strobe, taken at a rising edge when not busy |
| op_kind | input | 2 | 00 read, 01 write, 10 erase, 11 none |
| op_data | input | 1 | Bit value of a write |
| pw_valid | input | 1 | Presented password bit is valid |
| pw_bit | input | 1 | Presented password bit |
| perm | output | 2 | Access code for addr |
| verified | output | 1 | Transmission password proven |
| user_ok | output | 1 | User password proven |
| personalized | output | 1 | Personalization flag written |
| locked | output | 1 | Active attempt counter exhausted |
| busy | output | 1 | Comparison in progress |

## Verification
`perm` is combinational, so the bench samples it a few nanoseconds after changing `addr`. `busy`, `personalized` and the counter-based `locked` change at the edge that accepts the request, and are sampled at the following falling edge. `verified` and `user_ok` appear one edge after the edge that takes the last strobed bit. The bench therefore drops `pw_valid`, waits one more falling edge and then samples them. Random address sweeps in every lifecycle stage are compared with a bench function of the permission table.

// File: rtl/acs_pkg.sv
package acs_pkg;

    typedef enum logic [1:0] {
        PERM_RO     = 2'b00,
        PERM_OTP    = 2'b01,
        PERM_RW     = 2'b10,
        PERM_HIDDEN = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_ERASE = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        RG_MFR, RG_ISSUE, RG_ECNT, RG_TPW, RG_EXT, RG_UCNT, RG_UPW, RG_UDATA
    } region_e;

    typedef enum logic [1:0] {
        LC_OPEN, LC_VERIFIED, LC_PERS, LC_USER
    } life_e;

    typedef enum logic [1:0] {
        CS_IDLE, CS_COMPARE, CS_DECIDE
    } cmp_state_e;

    localparam int MFR_END    = 15;
    localparam int ISSUE_END  = 71;
    localparam int PFLAG_ADDR = 64;
    localparam int ECNT_END   = 79;
    localparam int TPW_LO     = 80;
    localparam int TPW_END    = 103;
    localparam int EXT_END    = 143;
    localparam int UCNT_END   = 151;
    localparam int UPW_END    = 159;
    localparam int TPW_BITS   = 24;
    localparam int UPW_BITS   = 8;
    localparam int CNT_BITS   = 8;
    localparam int NBYTES     = 2 + TPW_BITS / 8 + UPW_BITS / 8;

endpackage

// File: rtl/acs_perm_map.sv
module acs_perm_map
    import acs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              verified,
    input  logic              personalized,
    input  logic              user_ok,
    output region_e           region,
    output perm_e             perm
);
    logic [31:0] a_ext;
    life_e       life;

    assign a_ext = 32'(addr);

    always_comb begin
        if (personalized) life = user_ok ? LC_USER : LC_PERS;
        else              life = verified ? LC_VERIFIED : LC_OPEN;
    end

    always_comb begin
        if      (a_ext <= 32'(MFR_END))   region = RG_MFR;
        else if (a_ext <= 32'(ISSUE_END)) region = RG_ISSUE;
        else if (a_ext <= 32'(ECNT_END))  region = RG_ECNT;
        else if (a_ext <= 32'(TPW_END))   region = RG_TPW;
        else if (a_ext <= 32'(EXT_END))   region = RG_EXT;
        else if (a_ext <= 32'(UCNT_END))  region = RG_UCNT;
        else if (a_ext <= 32'(UPW_END))   region = RG_UPW;
        else                              region = RG_UDATA;
    end

    always_comb begin
        perm = PERM_RO;
        unique case (region)
            RG_MFR:   perm = PERM_RO;
            RG_ISSUE: perm = (life == LC_VERIFIED) ? PERM_OTP : PERM_RO;
            RG_ECNT:  perm = (life == LC_OPEN) ? PERM_OTP : PERM_RW;
            RG_TPW:   perm = (life == LC_OPEN) ? PERM_HIDDEN : PERM_RW;
            RG_EXT:   perm = (life == LC_VERIFIED) ? PERM_RW : PERM_RO;
            RG_UCNT: begin
                unique case (life)
                    LC_OPEN:     perm = PERM_RO;
                    LC_VERIFIED: perm = PERM_RW;
                    LC_PERS:     perm = PERM_OTP;
                    LC_USER:     perm = PERM_RW;
                endcase
            end
            RG_UPW: begin
                unique case (life)
                    LC_OPEN:     perm = PERM_RO;
                    LC_VERIFIED: perm = PERM_RW;
                    LC_PERS:     perm = PERM_HIDDEN;
                    LC_USER:     perm = PERM_RW;
                endcase
            end
            RG_UDATA: perm = (life == LC_VERIFIED || life == LC_USER) ? PERM_RW : PERM_RO;
            default:  perm = PERM_RO;
        endcase
    end

endmodule

// File: rtl/acs_secret_store.sv
module acs_secret_store #(
    parameter int                  NB   = 6,
    parameter logic [NB*8-1:0]     INIT = '1,
    localparam int                 SW   = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_zero,
    input  logic            erase,
    input  logic [SW-1:0]   byte_sel,
    input  logic [2:0]      bit_sel,
    output logic [NB*8-1:0] bits
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits[g*8 +: 8] <= INIT[g*8 +: 8];
            end else if (erase && byte_sel == SW'(g)) begin
                bits[g*8 +: 8] <= 8'hFF;
            end else if (wr_zero && byte_sel == SW'(g)) begin
                bits[g*8 + int'(bit_sel)] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/acs_cmp_seq.sv
module acs_cmp_seq
    import acs_pkg::*;
#(
    parameter int TBITS = 24,
    parameter int UBITS = 8,
    localparam int IW   = $clog2(TBITS),
    localparam int UW   = $clog2(UBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_t,
    input  logic             start_u,
    input  logic             pw_valid,
    input  logic             pw_bit,
    input  logic             locked,
    input  logic [TBITS-1:0] tref,
    input  logic [UBITS-1:0] uref,
    output logic             busy,
    output logic             pass_t,
    output logic             pass_u
);
    cmp_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          miss_q;
    logic          user_q;
    logic [IW-1:0] last_idx;
    logic          ref_bit;

    assign last_idx = user_q ? IW'(UBITS - 1) : IW'(TBITS - 1);

    always_comb begin
        if (user_q) ref_bit = uref[idx_q[UW-1:0]];
        else        ref_bit = (int'(idx_q) < TBITS) ? tref[idx_q] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:    if (start_t || start_u) state_d = CS_COMPARE;
            CS_COMPARE: if (pw_valid && idx_q == last_idx) state_d = CS_DECIDE;
            CS_DECIDE:  state_d = CS_IDLE;
            default:    state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            miss_q <= 1'b0;
            user_q <= 1'b0;
        end else if (state_q == CS_IDLE) begin
            idx_q  <= '0;
            miss_q <= 1'b0;
            if (start_t || start_u) user_q <= start_u;
        end else if (state_q == CS_COMPARE && pw_valid) begin
            miss_q <= miss_q | (pw_bit != ref_bit);
            idx_q  <= idx_q + 1'b1;
        end
    end

    always_comb begin
        busy   = (state_q != CS_IDLE);
        pass_t = (state_q == CS_DECIDE) && !miss_q && !locked && !user_q;
        pass_u = (state_q == CS_DECIDE) && !miss_q && !locked &&  user_q;
    end

    // R7
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_COMPARE) |-> (idx_q <= last_idx));

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_IDLE && (start_t || start_u)) |=> busy);

endmodule

// File: rtl/acs_access_ctrl.sv
module acs_access_ctrl
    import acs_pkg::*;
#(
    parameter int                   ADDR_W   = 8,
    parameter logic [TPW_BITS-1:0]  TPW_INIT = 24'h5A3C96,
    parameter logic [UPW_BITS-1:0]  UPW_INIT = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              op_req,
    input  logic [1:0]        op_kind,
    input  logic              op_data,
    input  logic              pw_valid,
    input  logic              pw_bit,
    output logic [1:0]        perm,
    output logic              verified,
    output logic              user_ok,
    output logic              personalized,
    output logic              locked,
    output logic              busy
);
    localparam int SW       = $clog2(NBYTES);
    localparam int TPW_BYTE = 1;
    localparam int UCNT_BYT = 1 + TPW_BITS / 8;
    localparam int UPW_BYTE = UCNT_BYT + 1;
    localparam logic [NBYTES*8-1:0] STORE_INIT =
        {UPW_INIT, {CNT_BITS{1'b1}}, TPW_INIT, {CNT_BITS{1'b1}}};

    region_e             region;
    perm_e               perm_c;
    logic [NBYTES*8-1:0] store;
    logic [SW-1:0]       byte_sel;
    logic [2:0]          bit_sel;
    logic                stored_rg, accept, wr_ok, we, ee, pflag_we;
    logic                cur_bit, start_t, start_u, pass_t, pass_u;
    logic                ver_q, uok_q, pflag_q;
    logic [31:0]         a_ext;
    logic [7:0]          ecnt, ucnt;

    acs_perm_map #(.ADDR_W(ADDR_W)) u_map (
        .addr(addr), .verified(ver_q), .personalized(~pflag_q),
        .user_ok(uok_q), .region(region), .perm(perm_c)
    );

    assign a_ext   = 32'(addr);
    assign bit_sel = addr[2:0];
    assign ecnt    = store[7:0];
    assign ucnt    = store[UCNT_BYT*8 +: 8];

    always_comb begin
        byte_sel  = '0;
        stored_rg = 1'b1;
        unique case (region)
            RG_ECNT: byte_sel = '0;
            RG_TPW:  byte_sel = SW'(TPW_BYTE + int'((a_ext - 32'(TPW_LO)) >> 3));
            RG_UCNT: byte_sel = SW'(UCNT_BYT);
            RG_UPW:  byte_sel = SW'(UPW_BYTE);
            default: stored_rg = 1'b0;
        endcase
    end

    assign cur_bit  = store[int'(byte_sel) * 8 + int'(bit_sel)];
    assign accept   = op_req && !busy;
    assign wr_ok    = accept && (op_kind == OP_WRITE) && !op_data &&
                      (perm_c == PERM_OTP || perm_c == PERM_RW);
    assign we       = wr_ok && stored_rg;
    assign ee       = accept && (op_kind == OP_ERASE) && (perm_c == PERM_RW) && stored_rg;
    assign pflag_we = wr_ok && (a_ext == 32'(PFLAG_ADDR));

    assign start_t = we && region == RG_ECNT && !ver_q && pflag_q && cur_bit &&
                     ($countones(ecnt) >= 2);
    assign start_u = we && region == RG_UCNT && !pflag_q && !uok_q && cur_bit &&
                     ($countones(ucnt) >= 2);

    acs_secret_store #(.NB(NBYTES), .INIT(STORE_INIT)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_zero(we), .erase(ee),
        .byte_sel(byte_sel), .bit_sel(bit_sel), .bits(store)
    );

    acs_cmp_seq #(.TBITS(TPW_BITS), .UBITS(UPW_BITS)) u_cmp (
        .clk(clk), .rst_n(rst_n), .start_t(start_t), .start_u(start_u),
        .pw_valid(pw_valid), .pw_bit(pw_bit), .locked(locked),
        .tref(store[TPW_BYTE*8 +: TPW_BITS]), .uref(store[UPW_BYTE*8 +: UPW_BITS]),
        .busy(busy), .pass_t(pass_t), .pass_u(pass_u)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ver_q   <= 1'b0;
            uok_q   <= 1'b0;
            pflag_q <= 1'b1;
        end else begin
            if (pflag_we) begin
                pflag_q <= 1'b0;
                ver_q   <= 1'b0;
            end else if (pass_t) begin
                ver_q <= 1'b1;
            end
            if (pass_u) uok_q <= 1'b1;
        end
    end

    always_comb begin
        perm         = perm_c;
        verified     = ver_q;
        user_ok      = uok_q;
        personalized = ~pflag_q;
        locked       = pflag_q ? (ecnt == 8'h00) : (ucnt == 8'h00);
    end

    // R9
    lock_hold_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !personalized && !verified) |=> !verified);

    // R13
    lock_hold_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && personalized && !user_ok) |=> !user_ok);

    // R12
    pers_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        personalized |-> !verified);

    // R11
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(store));

    // R10
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee && region == RG_ECNT) |=> (ecnt == 8'hFF));

endmodule

// File: tb/tb_acs_access_ctrl.sv
module tb_acs_access_ctrl;
    localparam logic [23:0] TPW = 24'h5A3C96;
    localparam logic [7:0]  UPW = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       op_req = 1'b0;
    logic [1:0] op_kind = 2'b11;
    logic       op_data = 1'b0;
    logic       pw_valid = 1'b0;
    logic       pw_bit = 1'b0;
    logic [1:0] perm;
    logic       verified, user_ok, personalized, locked, busy;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    acs_access_ctrl #(.ADDR_W(8), .TPW_INIT(TPW), .UPW_INIT(UPW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .op_req(op_req), .op_kind(op_kind),
        .op_data(op_data), .pw_valid(pw_valid), .pw_bit(pw_bit), .perm(perm),
        .verified(verified), .user_ok(user_ok), .personalized(personalized),
        .locked(locked), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stage: 0 OPEN, 1 VERIFIED, 2 PERSONALIZED, 3 USER
    function automatic logic [1:0] exp_perm(input int a, input int st);
        if (a <= 15)  return 2'b00;
        if (a <= 71)  return (st == 1) ? 2'b01 : 2'b00;
        if (a <= 79)  return (st == 0) ? 2'b01 : 2'b10;
        if (a <= 103) return (st == 0) ? 2'b11 : 2'b10;
        if (a <= 143) return (st == 1) ? 2'b10 : 2'b00;
        if (a <= 151) return (st == 0) ? 2'b00 : (st == 2) ? 2'b01 : 2'b10;
        if (a <= 159) return (st == 0) ? 2'b00 : (st == 2) ? 2'b11 : 2'b10;
        return (st == 1 || st == 3) ? 2'b10 : 2'b00;
    endfunction

    function automatic string req_of(input int a);
        if (a <= 15)  return "R1";
        if (a <= 71)  return "R2";
        if (a <= 79)  return "R3";
        if (a <= 103) return "R4";
        if (a <= 143 || a >= 160) return "R5";
        return "R6";
    endfunction

    task automatic probe(input int a, input int st);
        @(negedge clk);
        addr = 8'(a);
        #2;
        chk(perm == exp_perm(a, st), req_of(a), perm, exp_perm(a, st));
    endtask

    task automatic sweep(input int n, input int st);
        int bnd[19] = '{0, 15, 16, 23, 63, 64, 71, 72, 79, 80, 103, 104, 143,
                        144, 151, 152, 159, 160, 255};
        foreach (bnd[i]) probe(bnd[i], st);
        for (int k = 0; k < n; k++) probe(int'($urandom_range(0, 255)), st);
    endtask

    task automatic op(input logic [1:0] k, input int a, input bit d);
        @(negedge clk);
        addr = 8'(a); op_kind = k; op_data = d; op_req = 1'b1;
        @(negedge clk);
        op_req = 1'b0; op_kind = 2'b11;
    endtask

    task automatic feed(input logic [23:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            pw_valid = 1'b1; pw_bit = bits[i];
            @(negedge clk);
        end
        pw_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reset_checks();
        chk(!verified, "R14", verified, 0);
        chk(!user_ok, "R14", user_ok, 0);
        chk(!personalized, "R14", personalized, 0);
        chk(!locked, "R14", locked, 0);
        chk(!busy, "R14", busy, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7431));
        do_reset();
        reset_checks();
        sweep(40, 0);

        // R8: wrong password, with an ignored request while busy (R11)
        op(2'b01, 72, 1'b0);
        chk(busy, "R7", busy, 1);
        op(2'b01, 73, 1'b0);
        feed(TPW ^ 24'h000100, 24);
        chk(!verified, "R8", verified, 0);
        chk(!busy, "R8", busy, 0);

        // R11: bit 73 must still be set, so this starts a comparison
        op(2'b01, 73, 1'b0);
        chk(busy, "R11", busy, 1);
        feed(TPW, 24);
        chk(verified, "R7", verified, 1);
        chk(!busy, "R7", busy, 0);
        chk(!locked, "R7", locked, 0);
        sweep(40, 1);

        // R10: exhaust counter in VERIFIED, then erase
        for (int a = 74; a <= 79; a++) op(2'b01, a, 1'b0);
        chk(locked, "R10", locked, 1);
        chk(verified, "R10", verified, 1);
        op(2'b01, 72, 1'b1);
        chk(locked, "R11", locked, 1);
        op(2'b10, 76, 1'b0);
        chk(!locked, "R10", locked, 0);

        // R12: personalization
        op(2'b01, 64, 1'b1);
        chk(!personalized, "R11", personalized, 0);
        op(2'b01, 64, 1'b0);
        chk(personalized, "R12", personalized, 1);
        chk(!verified, "R12", verified, 0);
        chk(!locked, "R12", locked, 0);
        sweep(40, 2);

        // R13: user password flow
        op(2'b01, 144, 1'b0);
        chk(busy, "R13", busy, 1);
        feed({16'h0, UPW ^ 8'h01}, 8);
        chk(!user_ok, "R13", user_ok, 0);
        op(2'b01, 145, 1'b0);
        chk(busy, "R13", busy, 1);
        feed({16'h0, UPW}, 8);
        chk(user_ok, "R13", user_ok, 1);
        chk(!busy, "R13", busy, 0);
        sweep(40, 3);

        // R9: lockout after a fresh reset
        do_reset();
        reset_checks();
        for (int a = 72; a <= 78; a++) begin
            op(2'b01, a, 1'b0);
            chk(busy, "R9", busy, 1);
            feed(~TPW, 24);
            chk(!verified, "R9", verified, 0);
        end
        chk(!locked, "R9", locked, 0);
        op(2'b01, 79, 1'b0);
        chk(!busy, "R9", busy, 0);
        chk(locked, "R9", locked, 1);
        feed(TPW, 24);
        chk(!verified, "R9", verified, 0);
        probe(80, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule